// File: doc/BRIEF.md
# Shared Object Store with Single-Writer Arbitration

This block is the object memory that sits between a host bus and a physics update pipeline. Every word holds one complete object record, so either side can read or replace a whole object in one clock. The two sides each have their own port. Each port has an enable, a write select, an address, write data, registered read data and a ready flag that marks valid read data.

Both ports may read in the same cycle. Only one write can be committed per clock. When the pipeline and the host both try to write in one cycle, the pipeline write is stored and the host write is discarded. In that same cycle a failure flag goes to the host side so that its software can retry. A host write that meets no pipeline write is always committed.

The full-size store is built with a 13-bit address (8192 records of 256 bits). The parameter default is a smaller depth for elaboration. A read returns the contents as they were before any write committed in the same cycle.

Top module: `shared_obj_store`

## Requirements
- R1: One port access moves a whole record of DATA_W bits (256 in the full build). A record written through one port reads back bit-exact through either port.
- R2: Read data appears on the port's data output one clock after a read request. A read request is enable high with write select low.
- R3: Each port's ready output is high exactly in the cycle after that port made a read request. Both ready outputs are low after synchronous reset.
- R4: The two ports can read different addresses in the same cycle, and each receives its own record.
- R5: A host write (host enable and host write select high) with no pipeline write in the same cycle is committed.
- R6: A pipeline write is always committed.
- R7: When both ports write in one cycle, only the pipeline record is stored. The host record is dropped and its target address keeps its previous contents, whatever the two addresses are.
- R8: The host write-failure output is high, combinationally in the same cycle, exactly when both ports request a write. It is low otherwise.
- R9: A read of an address that the other port writes in the same cycle returns the record held before that write.
- R10: A port's read data output holds its last value in cycles that follow no read request on that port. It is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host port enable |
| host_we | input | 1 | Host write select (1 = write, 0 = read) |
| host_addr | input | ADDR_W | Host record address |
| host_wdata | input | DATA_W | Host write record |
| host_rdata | output | DATA_W | Host read record, registered |
| host_ready | output | 1 | Host read data valid |
| host_wfail | output | 1 | Host write rejected this cycle |
| pipe_en | input | 1 | Pipeline port enable |
| pipe_we | input | 1 | Pipeline write select (1 = write, 0 = read) |
| pipe_addr | input | ADDR_W | Pipeline record address |
| pipe_wdata | input | DATA_W | Pipeline write record |
| pipe_rdata | output | DATA_W | Pipeline read record, registered |
| pipe_ready | output | 1 | Pipeline read data valid |

## Verification
A host write and a pipeline write can fall in the same cycle. The bench provokes this for every pair of host and pipeline addresses in a 16-record build, including equal addresses. It judges the result by the failure flag in that cycle and by reading back both target addresses against a shadow model that stores only the pipeline record. A read on one port that meets a write on the other port to the same address is also driven, and the bench expects the old record.

// File: rtl/objmem_pkg.sv
package objmem_pkg;

    localparam int NUM_PORTS = 2;

    typedef enum logic [0:0] {
        PORT_HOST = 1'b0,
        PORT_PIPE = 1'b1
    } port_id_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } access_t;

    function automatic access_t decode_access(input logic en, input logic we);
        access_t a;
        a.rd = en & ~we;
        a.wr = en & we;
        return a;
    endfunction

endpackage

// File: rtl/objmem_arb.sv
module objmem_arb
    import objmem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  access_t  host_acc,
    input  access_t  pipe_acc,
    output logic     commit,
    output port_id_e winner,
    output logic     host_reject
);
    always_comb begin
        commit      = host_acc.wr | pipe_acc.wr;
        winner      = pipe_acc.wr ? PORT_PIPE : PORT_HOST;
        host_reject = host_acc.wr & pipe_acc.wr;
    end

    // R5: a lone host write is granted
    assert_host_alone_R5: assert property (@(posedge clk) disable iff (rst)
        (host_acc.wr && !pipe_acc.wr) |-> (commit && winner == PORT_HOST && !host_reject));

    // R6: a pipeline write always wins
    assert_pipe_wins_R6: assert property (@(posedge clk) disable iff (rst)
        pipe_acc.wr |-> (commit && winner == PORT_PIPE));

    // R8: rejection only on a genuine collision
    assert_reject_only_collision_R8: assert property (@(posedge clk) disable iff (rst)
        host_reject |-> (host_acc.wr && winner == PORT_PIPE));
endmodule

// File: rtl/objmem_array.sv
module objmem_array
    import objmem_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int ADDR_W = 11
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [ADDR_W-1:0]                   waddr,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic [NUM_PORTS-1:0]                rd_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    rd_addr,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]    rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data[p] <= '0;
            end else if (rd_en[p]) begin
                rd_data[p] <= mem[rd_addr[p]];
            end
        end
    end
endmodule

// File: rtl/objmem_rdport.sv
module objmem_rdport (
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    output logic ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
        end else begin
            ready <= rd_req;
        end
    end
endmodule

// File: rtl/shared_obj_store.sv
module shared_obj_store
    import objmem_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              host_wfail,
    input  logic              pipe_en,
    input  logic              pipe_we,
    input  logic [ADDR_W-1:0] pipe_addr,
    input  logic [DATA_W-1:0] pipe_wdata,
    output logic [DATA_W-1:0] pipe_rdata,
    output logic              pipe_ready
);
    access_t  host_acc, pipe_acc;
    logic     commit;
    port_id_e winner;

    logic [NUM_PORTS-1:0]             rd_en;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] rd_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] rd_data;
    logic [NUM_PORTS-1:0]             ready;

    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;

    assign host_acc = decode_access(host_en, host_we);
    assign pipe_acc = decode_access(pipe_en, pipe_we);

    objmem_arb u_arb (
        .clk         (clk),
        .rst         (rst),
        .host_acc    (host_acc),
        .pipe_acc    (pipe_acc),
        .commit      (commit),
        .winner      (winner),
        .host_reject (host_wfail)
    );

    always_comb begin
        waddr = (winner == PORT_PIPE) ? pipe_addr  : host_addr;
        wdata = (winner == PORT_PIPE) ? pipe_wdata : host_wdata;
    end

    assign rd_en[PORT_HOST]   = host_acc.rd;
    assign rd_en[PORT_PIPE]   = pipe_acc.rd;
    assign rd_addr[PORT_HOST] = host_addr;
    assign rd_addr[PORT_PIPE] = pipe_addr;

    objmem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .we      (commit),
        .waddr   (waddr),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        objmem_rdport u_rdport (
            .clk    (clk),
            .rst    (rst),
            .rd_req (rd_en[p]),
            .ready  (ready[p])
        );
    end

    assign host_rdata = rd_data[PORT_HOST];
    assign pipe_rdata = rd_data[PORT_PIPE];
    assign host_ready = ready[PORT_HOST];
    assign pipe_ready = ready[PORT_PIPE];

    // R3: ready tracks the previous cycle's read request at the ports
    assert_host_ready_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (host_ready == $past(host_en && !host_we)));
    assert_pipe_ready_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pipe_ready == $past(pipe_en && !pipe_we)));

    // R10: read data holds when the previous cycle made no read
    assert_host_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(host_en && !host_we)) |-> $stable(host_rdata));
    assert_pipe_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pipe_en && !pipe_we)) |-> $stable(pipe_rdata));

    // R8: failure flag exactly on a double write request at the ports
    assert_wfail_R8: assert property (@(posedge clk) disable iff (rst)
        host_wfail == (host_en && host_we && pipe_en && pipe_we));
endmodule

// File: tb/shared_obj_store_test.sv
module shared_obj_store_test;
    localparam int DW = 256;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_en = 0, host_we = 0, pipe_en = 0, pipe_we = 0;
    logic [AW-1:0] host_addr = '0, pipe_addr = '0;
    logic [DW-1:0] host_wdata = '0, pipe_wdata = '0;
    logic [DW-1:0] host_rdata, pipe_rdata;
    logic          host_ready, pipe_ready, host_wfail;

    int compared = 0;
    int mismatched = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] exp_hrd = '0, exp_prd = '0;

    always #4 clk = ~clk;

    shared_obj_store #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .host_wfail(host_wfail),
        .pipe_en(pipe_en), .pipe_we(pipe_we), .pipe_addr(pipe_addr),
        .pipe_wdata(pipe_wdata), .pipe_rdata(pipe_rdata),
        .pipe_ready(pipe_ready)
    );

    function automatic logic [DW-1:0] pat(input int a, input int s);
        logic [DW-1:0] v;
        for (int i = 0; i < DW / 32; i++) begin
            v[i*32 +: 32] = 32'(a) * 32'h9E3779B1 + 32'(s) * 32'h7F4A7C15 + 32'(i) * 32'h01000193;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // one cycle of stimulus, checked against the shadow model
    task automatic step(input string tag,
                        input logic he, input logic hw, input int ha, input logic [DW-1:0] hd,
                        input logic pe, input logic pw, input int pa, input logic [DW-1:0] pd);
        logic hr, pr, coll;
        host_en = he; host_we = hw; host_addr = AW'(ha); host_wdata = hd;
        pipe_en = pe; pipe_we = pw; pipe_addr = AW'(pa); pipe_wdata = pd;
        #1;
        coll = he && hw && pe && pw;
        chk({tag, " R8 wfail"}, DW'(host_wfail), DW'(coll));
        hr = he && !hw;
        pr = pe && !pw;
        if (hr) exp_hrd = model[ha];
        if (pr) exp_prd = model[pa];
        if (pe && pw) model[pa] = pd;
        if (he && hw && !coll) model[ha] = hd;
        @(posedge clk);
        #2;
        chk({tag, " R3 host_ready"}, DW'(host_ready), DW'(hr));
        chk({tag, " R3 pipe_ready"}, DW'(pipe_ready), DW'(pr));
        chk({tag, hr ? " R2 host_rdata" : " R10 host_rdata"}, host_rdata, exp_hrd);
        chk({tag, pr ? " R2 pipe_rdata" : " R10 pipe_rdata"}, pipe_rdata, exp_prd);
        host_en = 0; host_we = 0; pipe_en = 0; pipe_we = 0;
    endtask

    initial begin
        #(8 * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        chk("R3 reset host_ready", DW'(host_ready), '0);
        chk("R3 reset pipe_ready", DW'(pipe_ready), '0);
        chk("R10 reset host_rdata", host_rdata, '0);
        chk("R10 reset pipe_rdata", pipe_rdata, '0);

        // R5: host fills every record alone; R1 read back through pipe
        for (int a = 0; a < DEPTH; a++)
            step("R5 host write", 1, 1, a, pat(a, 1), 0, 0, 0, '0);
        for (int a = 0; a < DEPTH; a++)
            step("R1 pipe readback", 0, 0, 0, '0, 1, 0, a, '0);

        // R6: pipeline overwrites alone; R1 read back through host
        for (int a = 0; a < DEPTH; a++)
            step("R6 pipe write", 0, 0, 0, '0, 1, 1, a, pat(a, 2));
        for (int a = 0; a < DEPTH; a++)
            step("R1 host readback", 1, 0, a, '0, 0, 0, 0, '0);

        // R4: concurrent reads on different addresses
        for (int a = 0; a < DEPTH; a++)
            step("R4 dual read", 1, 0, a, '0, 1, 0, DEPTH - 1 - a, '0);

        // R10: idle cycles hold last data
        step("R10 idle", 0, 0, 0, '0, 0, 0, 0, '0);
        step("R10 pipe write only", 0, 0, 3, '0, 1, 1, 5, pat(5, 3));

        // R9: read meets other port's write to the same address
        for (int a = 0; a < DEPTH; a++) begin
            step("R9 host read vs pipe write", 1, 0, a, '0, 1, 1, a, pat(a, 4));
            step("R9 pipe read vs host write", 1, 1, a, pat(a, 5), 1, 0, a, '0);
        end

        // R7/R8: every address pair collides, then both targets read back
        for (int ha = 0; ha < DEPTH; ha++) begin
            for (int pa = 0; pa < DEPTH; pa++) begin
                step("R7 collision", 1, 1, ha, pat(ha, 100 + pa), 1, 1, pa, pat(pa, 200 + ha));
                step("R7 readback", 1, 0, ha, '0, 1, 0, pa, '0);
            end
            step("R5 host after collision", 1, 1, ha, pat(ha, 300), 0, 0, 0, '0);
        end

        // R8: host write against a pipeline read raises no failure
        step("R8 host write vs pipe read", 1, 1, 2, pat(2, 7), 1, 0, 9, '0);
        step("R8 readback", 1, 0, 2, '0, 0, 0, 0, '0);

        summary();
    end
endmodule